// File: doc/BRIEF.md
# Two-Stage Interrupt Priority Selector

This block looks at a fixed set of interrupt sources, each with a pending flag and a priority value, and picks the one pending source that is most favoured. A smaller priority number is more favoured. The result is registered once per clock and gives the chosen source's index, its priority, and a valid flag. The valid flag rises only when the chosen priority beats a current-priority threshold supplied by the surrounding logic.

The selection does not use a chain of pairwise comparators. It first folds all live pending sources into a summary vector with one bit per priority level. A lowest-set-bit encoder turns that vector into the best level. It then builds a match vector with one bit per source: a bit is set when the source is pending at that level. A second encoder of the same kind turns the match vector into the lowest matching source index. Priority value all-ones marks a source as masked.

All pins are plain level signals. There is no valid/ready handshake and no back-pressure. The output is a status that the block recomputes on every clock from the current inputs, so a consumer samples it whenever it likes and nothing is held or queued.

Top module: `irq_prio_select`

## Requirements
- R1: While `rst_n` is low, the outputs are `irq_valid_o`=0, `irq_src_o`=0 and `irq_prio_o`=all ones (0xFF).
- R2: Among pending, unmasked sources, the reported priority is the numerically smallest one. Source i's priority is `prio_i[i*8 +: 8]`.
- R3: When several pending sources share the best priority, the reported source is the one with the smallest index.
- R4: A source whose priority is 0xFF is masked. It is never reported, even when it is pending.
- R5: A source whose pending bit is 0 has no effect on the outputs, whatever its priority.
- R6: `irq_valid_o` is 1 only when the reported priority is strictly less than `cur_prio_i`. When the reported priority is equal to or above the threshold, `irq_valid_o` is 0, and `irq_src_o`/`irq_prio_o` still show the best candidate.
- R7: When no unmasked source is pending, the outputs are `irq_valid_o`=0, `irq_prio_o`=0xFF and `irq_src_o`=0.
- R8: The outputs reflect the inputs sampled at the previous rising clock edge. A change to an input does not show on an output until the next rising edge.
- R9: Priorities 0x00 and 0xFE are ordinary levels. Both can be selected, and 0x00 with `cur_prio_i`=0x01 raises `irq_valid_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| pend_i | input | 16 | Pending flag per source, bit i = source i |
| prio_i | input | 128 | Packed priorities, source i in bits [i*8+7:i*8] |
| cur_prio_i | input | 8 | Current-priority threshold |
| irq_valid_o | output | 1 | Chosen interrupt beats the threshold |
| irq_src_o | output | 4 | Index of the chosen source |
| irq_prio_o | output | 8 | Priority of the chosen source, 0xFF when idle |

## Verification
Several kinds of input pattern are used, and each one separates a different fault:
- A single pending source, and then several sources at distinct priorities, show whether stage one finds the minimum level.
- Equal priorities spread across different indices separate a lowest-index tie-break from a highest-index one.
- Masked sources and non-pending sources carrying very favoured priorities expose any leak of masking or pending into the summary vector.
- A threshold swept through below, equal and above the best priority pins down the strict comparison.
- A long pseudo-random sweep is compared against a straightforward linear search.

// File: rtl/irqsel_pkg.sv
package irqsel_pkg;
  parameter int unsigned DEF_SRC_N  = 16;
  parameter int unsigned DEF_PRIO_W = 8;
endpackage

// File: rtl/irqsel_lowest_enc.sv
// Lowest-set-bit encoder: isolates the least significant one (v & -v)
// and ORs the isolated bit into each index bit, giving the trailing-zero count.
module irqsel_lowest_enc #(
  parameter int unsigned WIDTH = 16,
  localparam int unsigned IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic [WIDTH-1:0] vec_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             found_o
);
  logic [WIDTH-1:0] iso;

  assign iso     = vec_i & (~vec_i + WIDTH'(1));
  assign found_o = |vec_i;

  for (genvar b = 0; b < IDX_W; b++) begin : g_bit
    always_comb begin
      idx_o[b] = 1'b0;
      for (int i = 0; i < WIDTH; i++) begin
        if (((i >> b) & 1) == 1) idx_o[b] = idx_o[b] | iso[i];
      end
    end
  end
endmodule

// File: rtl/irqsel_level_summary.sv
// Stage one: one bit per priority level, set when any live source sits there.
module irqsel_level_summary #(
  parameter int unsigned SRC_N  = 16,
  parameter int unsigned PRIO_W = 8,
  localparam int unsigned LEVELS = 1 << PRIO_W
) (
  input  logic [SRC_N-1:0]        live_i,
  input  logic [SRC_N*PRIO_W-1:0] prio_i,
  output logic [LEVELS-1:0]       level_vec_o
);
  for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
    always_comb begin
      level_vec_o[l] = 1'b0;
      for (int s = 0; s < SRC_N; s++) begin
        if (live_i[s] && (prio_i[s*PRIO_W +: PRIO_W] == PRIO_W'(l)))
          level_vec_o[l] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/irqsel_source_match.sv
// Stage two: one bit per source, set when the source is live at the chosen level.
module irqsel_source_match #(
  parameter int unsigned SRC_N  = 16,
  parameter int unsigned PRIO_W = 8
) (
  input  logic [SRC_N-1:0]        live_i,
  input  logic [SRC_N*PRIO_W-1:0] prio_i,
  input  logic [PRIO_W-1:0]       level_i,
  output logic [SRC_N-1:0]        match_o
);
  for (genvar s = 0; s < SRC_N; s++) begin : g_src
    assign match_o[s] = live_i[s] && (prio_i[s*PRIO_W +: PRIO_W] == level_i);
  end
endmodule

// File: rtl/irq_prio_select.sv
module irq_prio_select
  import irqsel_pkg::*;
#(
  parameter int unsigned SRC_N  = DEF_SRC_N,
  parameter int unsigned PRIO_W = DEF_PRIO_W,
  localparam int unsigned LEVELS = 1 << PRIO_W,
  localparam int unsigned SRC_W  = (SRC_N > 1) ? $clog2(SRC_N) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [SRC_N-1:0]        pend_i,
  input  logic [SRC_N*PRIO_W-1:0] prio_i,
  input  logic [PRIO_W-1:0]       cur_prio_i,
  output logic                    irq_valid_o,
  output logic [SRC_W-1:0]        irq_src_o,
  output logic [PRIO_W-1:0]       irq_prio_o
);
  localparam logic [PRIO_W-1:0] MASK_LVL = {PRIO_W{1'b1}};

  logic [SRC_N-1:0]  live;
  logic [LEVELS-1:0] level_vec;
  logic [PRIO_W-1:0] best_lvl;
  logic              lvl_found;
  logic [SRC_N-1:0]  match_vec;
  logic [SRC_W-1:0]  best_src;
  logic              src_found;

  // Pending masking: all-ones priority never takes part.
  for (genvar s = 0; s < SRC_N; s++) begin : g_live
    assign live[s] = pend_i[s] && (prio_i[s*PRIO_W +: PRIO_W] != MASK_LVL);
  end

  irqsel_level_summary #(.SRC_N(SRC_N), .PRIO_W(PRIO_W)) u_summary (
    .live_i(live), .prio_i(prio_i), .level_vec_o(level_vec)
  );

  irqsel_lowest_enc #(.WIDTH(LEVELS)) u_lvl_enc (
    .vec_i(level_vec), .idx_o(best_lvl), .found_o(lvl_found)
  );

  irqsel_source_match #(.SRC_N(SRC_N), .PRIO_W(PRIO_W)) u_match (
    .live_i(live), .prio_i(prio_i), .level_i(best_lvl), .match_o(match_vec)
  );

  irqsel_lowest_enc #(.WIDTH(SRC_N)) u_src_enc (
    .vec_i(match_vec), .idx_o(best_src), .found_o(src_found)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_valid_o <= 1'b0;
      irq_src_o   <= '0;
      irq_prio_o  <= MASK_LVL;
    end else if (lvl_found) begin
      irq_valid_o <= best_lvl < cur_prio_i;
      irq_src_o   <= best_src;
      irq_prio_o  <= best_lvl;
    end else begin
      irq_valid_o <= 1'b0;
      irq_src_o   <= '0;
      irq_prio_o  <= MASK_LVL;
    end
  end

  // Checks on stage agreement and registered outputs.
  assert_stage_agree_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_found |-> src_found);

  assert_tie_lowest_R3: assert property (@(posedge clk) disable iff (!rst_n)
    src_found |-> ((match_vec & ((SRC_N'(1) << best_src) - SRC_N'(1))) == '0));

  assert_never_masked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid_o |-> (irq_prio_o != MASK_LVL));

  assert_src_was_pending_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid_o |-> ((($past(pend_i) >> irq_src_o) & SRC_N'(1)) != '0));

  assert_strict_threshold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid_o |-> (irq_prio_o < $past(cur_prio_i)));

  assert_idle_outputs_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (live == '0) |=> (!irq_valid_o && irq_prio_o == MASK_LVL && irq_src_o == '0));
endmodule

// File: tb/irq_prio_select_test.sv
`timescale 1ns/1ps
module irq_prio_select_test;
  localparam int N = 16;
  localparam int W = 8;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [N-1:0]   pend_i = '0;
  logic [N*W-1:0] prio_i = '1;
  logic [W-1:0]   cur_prio_i = '1;
  logic           irq_valid_o;
  logic [3:0]     irq_src_o;
  logic [W-1:0]   irq_prio_o;

  int n_checks = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  irq_prio_select uut (
    .clk(clk), .rst_n(rst_n), .pend_i(pend_i), .prio_i(prio_i),
    .cur_prio_i(cur_prio_i), .irq_valid_o(irq_valid_o),
    .irq_src_o(irq_src_o), .irq_prio_o(irq_prio_o)
  );

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog: run did not finish, got hang expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  task automatic check3(string req, logic ev, logic [3:0] es, logic [7:0] ep);
    n_checks++;
    if (irq_valid_o !== ev || irq_src_o !== es || irq_prio_o !== ep) begin
      n_fail++;
      $display("FAIL %s: got valid=%0b src=%0d prio=%02h expected valid=%0b src=%0d prio=%02h",
               req, irq_valid_o, irq_src_o, irq_prio_o, ev, es, ep);
    end
  endtask

  // Independent linear-search model of the requirements.
  task automatic model(input logic [N-1:0] p, input logic [N*W-1:0] pr,
                       input logic [W-1:0] cur,
                       output logic v, output logic [3:0] s, output logic [7:0] b);
    b = 8'hFF; s = 0;
    for (int i = 0; i < N; i++) begin
      if (p[i] && pr[i*W +: W] != 8'hFF && pr[i*W +: W] < b) begin
        b = pr[i*W +: W]; s = 4'(i);
      end
    end
    v = (b != 8'hFF) && (b < cur);
  endtask

  task automatic apply(string req, input logic [N-1:0] p,
                       input logic [N*W-1:0] pr, input logic [W-1:0] cur);
    logic v; logic [3:0] s; logic [7:0] b;
    @(negedge clk);
    pend_i = p; prio_i = pr; cur_prio_i = cur;
    model(p, pr, cur, v, s, b);
    @(posedge clk); #1;
    check3(req, v, s, b);
  endtask

  function automatic logic [N*W-1:0] all_prio(logic [7:0] val);
    logic [N*W-1:0] r;
    for (int i = 0; i < N; i++) r[i*W +: W] = val;
    return r;
  endfunction

  task automatic t_reset();
    repeat (3) @(posedge clk);
    #1;
    check3("R1 reset state", 1'b0, 4'd0, 8'hFF);
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic t_idle();
    apply("R7 nothing pending", '0, all_prio(8'h10), 8'hFF);
    check3("R7 idle explicit", 1'b0, 4'd0, 8'hFF);
  endtask

  task automatic t_lowest_wins();
    logic [N*W-1:0] pr = all_prio(8'h80);
    pr[3*W +: W] = 8'h40; pr[9*W +: W] = 8'h20; pr[12*W +: W] = 8'h30;
    apply("R2 lowest value wins", 16'h1208, pr, 8'hFF);
    check3("R2 expected src9", 1'b1, 4'd9, 8'h20);
    apply("R2 single source", 16'h0008, pr, 8'hFF);
    apply("R2 all pending", 16'hFFFF, pr, 8'hFF);
  endtask

  task automatic t_tie();
    logic [N*W-1:0] pr = all_prio(8'h50);
    pr[5*W +: W] = 8'h11; pr[7*W +: W] = 8'h11; pr[14*W +: W] = 8'h11;
    apply("R3 tie to lowest index", 16'h40A0, pr, 8'hFF);
    check3("R3 expected src5", 1'b1, 4'd5, 8'h11);
    apply("R3 tie all equal", 16'hFFF0, all_prio(8'h22), 8'hFF);
    check3("R3 expected src4", 1'b1, 4'd4, 8'h22);
  endtask

  task automatic t_masked();
    logic [N*W-1:0] pr = all_prio(8'h60);
    pr[0*W +: W] = 8'hFF;
    apply("R4 masked skipped", 16'h0005, pr, 8'hFF);
    check3("R4 expected src2", 1'b1, 4'd2, 8'h60);
    apply("R4 all masked", 16'hFFFF, all_prio(8'hFF), 8'hFF);
    check3("R4 all masked idle", 1'b0, 4'd0, 8'hFF);
  endtask

  task automatic t_ignore();
    logic [N*W-1:0] pr = all_prio(8'h70);
    pr[1*W +: W] = 8'h00; pr[11*W +: W] = 8'h05;
    apply("R5 non-pending ignored", 16'h0400, pr, 8'hFF);
    check3("R5 expected src10", 1'b1, 4'd10, 8'h70);
  endtask

  task automatic t_threshold();
    logic [N*W-1:0] pr = all_prio(8'h90);
    pr[6*W +: W] = 8'h33;
    apply("R6 below threshold", 16'h0040, pr, 8'h34);
    check3("R6 valid", 1'b1, 4'd6, 8'h33);
    apply("R6 equal threshold", 16'h0040, pr, 8'h33);
    check3("R6 equal no valid", 1'b0, 4'd6, 8'h33);
    apply("R6 above threshold", 16'h0040, pr, 8'h10);
    check3("R6 above no valid", 1'b0, 4'd6, 8'h33);
  endtask

  task automatic t_latency();
    logic [N*W-1:0] pr = all_prio(8'h44);
    apply("R8 setup", 16'h0100, pr, 8'hFF);
    @(negedge clk);
    pend_i = 16'h0002; pr[1*W +: W] = 8'h01; prio_i = pr;
    #1;
    check3("R8 holds before edge", 1'b1, 4'd8, 8'h44);
    @(posedge clk); #1;
    check3("R8 updates after edge", 1'b1, 4'd1, 8'h01);
  endtask

  task automatic t_extremes();
    logic [N*W-1:0] pr = all_prio(8'hFE);
    apply("R9 level FE", 16'h8000, pr, 8'hFF);
    check3("R9 FE selected", 1'b1, 4'd15, 8'hFE);
    pr[13*W +: W] = 8'h00;
    apply("R9 level 00", 16'hA000, pr, 8'h01);
    check3("R9 00 valid", 1'b1, 4'd13, 8'h00);
    apply("R9 00 vs threshold 00", 16'hA000, pr, 8'h00);
  endtask

  task automatic t_sweep();
    logic [31:0] lfsr = 32'hACE1_2468;
    for (int k = 0; k < 300; k++) begin
      logic [N*W-1:0] pr;
      logic [N-1:0] p;
      for (int i = 0; i < N*W/32; i++) begin
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        lfsr = lfsr ^ (lfsr << 13) ^ (lfsr >> 7);
        pr[i*32 +: 32] = lfsr;
      end
      for (int i = 0; i < N; i++) pr[i*W +: 4] = (k % 3 == 0) ? 4'h0 : pr[i*W +: 4];
      p = lfsr[N-1:0] ^ lfsr[31:16];
      apply("R2 R3 sweep", p, pr, lfsr[7:0] | 8'h20);
    end
  endtask

  initial begin
    t_reset();
    t_idle();
    t_lowest_wins();
    t_tie();
    t_masked();
    t_ignore();
    t_threshold();
    t_latency();
    t_extremes();
    t_sweep();
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule